// File: doc/BRIEF.md
# Sleep, Wake and Power-Down Sequencer

This block decides when the internal clock domains of a device may run. It follows a level-sensitive wake request, an active-low power-down request, an active-low hardware reset, and the host's SPI chip select. From these it drives a mode indicator for the host and one clock-enable line for each internal clock domain. The SPI engine reports through a busy input, so the sequencer knows when a host access that woke the device has finished.

After reset is released, the block waits for a programmable number of cycles before it enables any clock. It then enters the operating mode or the sleep mode, depending on the wake request. While the device sleeps, a falling edge on chip select wakes it for the duration of a host access, even when the wake request is low. Once the access is finished, the wake request is sampled again. Power-down overrides every other input, and only a hardware reset can leave it. All external inputs cross into the local clock through synchronisers.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_ind` is 0 and every bit of `clk_en` is 0, regardless of the clock.
- R2: After `rst_n` rises, with the wake request high and no power-down, `mode_ind` first reads 1 no earlier than STARTUP_CYCLES and no later than STARTUP_CYCLES+4 rising clock edges later. Until then, all enables stay 0.
- R3: Each input passes through a two-stage synchroniser. An input change set up before rising edge n shows on the outputs only after edge n+2, and the outputs are still unchanged after edge n+1.
- R4: In operating mode, a low wake request moves the block to sleep. In sleep, `mode_ind` is 0 and `clk_en` equals SLEEP_KEEP_MASK (bit d set keeps domain d clocked in sleep).
- R5: In sleep, a high wake request moves the block to operating mode. In operating mode, `mode_ind` is 1 and all bits of `clk_en` are 1.
- R6: In sleep, a high-to-low transition of `spi_cs_n` starts a host-wake mode, which shows as operating (`mode_ind` 1, all enables 1). A chip select that is already low, with no fresh falling edge, does not wake the block.
- R7: Host-wake mode persists while `spi_cs_n` is low or `spi_busy` is high, whatever the wake request does.
- R8: When `spi_cs_n` is high and `spi_busy` is low in host-wake mode, the block goes to operating mode if the wake request is high, and to sleep otherwise.
- R9: A low `pdn_n` puts the block in power-down from any mode, ahead of wake and chip select. In power-down, `mode_ind` is 0 and all enables are 0.
- R10: Power-down persists through any activity on `pdn_n`, `wake`, `spi_cs_n` and `spi_busy`. A subsequent reset restarts the normal start-up sequence.
- R11: A chip-select falling edge in operating mode leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset; release is synchronised |
| wake | input | 1 | Level wake request: high for operating mode, low for sleep |
| pdn_n | input | 1 | Active-low power-down request |
| spi_cs_n | input | 1 | Host SPI chip select, active low |
| spi_busy | input | 1 | High while the SPI engine is still serving a request |
| mode_ind | output | 1 | 1 in operating or host-wake mode, 0 otherwise |
| clk_en | output | NUM_DOMAINS | Enable for each internal clock-domain gate |

## Verification
The hardest situation to reach is a chip select that is already low when the block enters sleep. A wrong design could treat that level as a wake event. The bench reaches it by lowering chip select while the block is operating and then dropping the wake request. A second hard case is a host access whose busy phase outlasts chip select while the wake request changes. Directed sequences cover both. A fixed-seed random walk over wake, chip select, busy and occasional power-down then checks every settled step against a bench model of the mode transitions.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      PS_BOOT  = 3'd0,
      PS_RUN   = 3'd1,
      PS_SLEEP = 3'd2,
      PS_HOST  = 3'd3,
      PS_OFF   = 3'd4
   } pwr_mode_e;

   function automatic logic mode_is_active(input pwr_mode_e m);
      return (m == PS_RUN) || (m == PS_HOST);
   endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
`timescale 1ns/1ps
module pwr_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_sync.sv
`timescale 1ns/1ps
module pwr_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pwr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
   import pwr_seq_pkg::*;
#(
   parameter int STARTUP_CYCLES = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wake_s,
   input  logic      pdn_n_s,
   input  logic      cs_n_s,
   input  logic      busy_s,
   output pwr_mode_e mode
);

   localparam int CNT_W = (STARTUP_CYCLES < 2) ? 1 : $clog2(STARTUP_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYCLES - 1);

   if (STARTUP_CYCLES < 1) begin : g_bad_startup
      $error("pwr_mode_fsm: STARTUP_CYCLES must be at least 1");
   end

   pwr_mode_e         mode_q, mode_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              cs_prev_q;
   logic              cs_fall;

   assign cs_fall = cs_prev_q & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_prev_q <= 1'b1;
      else        cs_prev_q <= cs_n_s;
   end

   always_comb begin
      mode_d = mode_q;
      cnt_d  = cnt_q;
      if ((mode_q != PS_OFF) && !pdn_n_s) begin
         mode_d = PS_OFF;
      end else begin
         unique case (mode_q)
            PS_BOOT: begin
               if (cnt_q == CNT_LAST) mode_d = wake_s ? PS_RUN : PS_SLEEP;
               else                   cnt_d  = cnt_q + 1'b1;
            end
            PS_RUN: begin
               if (!wake_s) mode_d = PS_SLEEP;
            end
            PS_SLEEP: begin
               if (wake_s)       mode_d = PS_RUN;
               else if (cs_fall) mode_d = PS_HOST;
            end
            PS_HOST: begin
               if (cs_n_s && !busy_s) mode_d = wake_s ? PS_RUN : PS_SLEEP;
            end
            default: mode_d = PS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PS_BOOT;
         cnt_q  <= '0;
      end else begin
         mode_q <= mode_d;
         cnt_q  <= cnt_d;
      end
   end

   assign mode = mode_q;

   // R9: power-down request wins over every other input
   assert_pdn_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_n_s |=> (mode_q == PS_OFF));

   // R10: nothing but reset leaves power-down
   assert_pdn_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PS_OFF) |=> (mode_q == PS_OFF));

   // R4: operating mode drops to sleep on a low wake request
   assert_run_to_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PS_RUN && pdn_n_s && !wake_s) |=> (mode_q == PS_SLEEP));

   // R5: sleep rises to operating mode on a high wake request
   assert_sleep_to_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PS_SLEEP && pdn_n_s && wake_s) |=> (mode_q == PS_RUN));

   // R6: a chip-select falling edge in sleep starts a host wake
   assert_cs_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PS_SLEEP && pdn_n_s && !wake_s && $fell(cs_n_s)) |=> (mode_q == PS_HOST));

   // R7: an unfinished host access keeps the device awake
   assert_host_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PS_HOST && pdn_n_s && (!cs_n_s || busy_s)) |=> (mode_q == PS_HOST));

   // R11: chip select leaves operating mode alone
   assert_run_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PS_RUN && pdn_n_s && wake_s) |=> (mode_q == PS_RUN));

endmodule

// File: rtl/pwr_clk_en_gen.sv
`timescale 1ns/1ps
module pwr_clk_en_gen
   import pwr_seq_pkg::*;
#(
   parameter int                     NUM_DOMAINS     = 4,
   parameter logic [NUM_DOMAINS-1:0] SLEEP_KEEP_MASK = '0
) (
   input  pwr_mode_e              mode,
   output logic                   mode_ind,
   output logic [NUM_DOMAINS-1:0] clk_en
);

   if (NUM_DOMAINS < 1) begin : g_bad_domains
      $error("pwr_clk_en_gen: NUM_DOMAINS must be at least 1");
   end

   logic active;
   logic asleep;

   assign active   = mode_is_active(mode);
   assign asleep   = (mode == PS_SLEEP);
   assign mode_ind = active;

   for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
      if (SLEEP_KEEP_MASK[d]) begin : g_keep
         assign clk_en[d] = active | asleep;
      end else begin : g_gate
         assign clk_en[d] = active;
      end
   end

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int                     NUM_DOMAINS     = 4,
   parameter int                     STARTUP_CYCLES  = 16,
   parameter int                     SYNC_STAGES     = 2,
   parameter logic [NUM_DOMAINS-1:0] SLEEP_KEEP_MASK = NUM_DOMAINS'(1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wake,
   input  logic                   pdn_n,
   input  logic                   spi_cs_n,
   input  logic                   spi_busy,
   output logic                   mode_ind,
   output logic [NUM_DOMAINS-1:0] clk_en
);

   localparam int               IN_W    = 4;
   localparam logic [IN_W-1:0]  IN_RST  = 4'b0110; // {busy, cs_n, pdn_n, wake}

   logic             srst_n;
   logic [IN_W-1:0]  in_raw, in_s;
   pwr_mode_e        mode;

   pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (clk),
      .arst_n (rst_n),
      .srst_n (srst_n)
   );

   assign in_raw = {spi_busy, spi_cs_n, pdn_n, wake};

   pwr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
      .clk   (clk),
      .rst_n (srst_n),
      .d     (in_raw),
      .q     (in_s)
   );

   pwr_mode_fsm #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_fsm (
      .clk     (clk),
      .rst_n   (srst_n),
      .wake_s  (in_s[0]),
      .pdn_n_s (in_s[1]),
      .cs_n_s  (in_s[2]),
      .busy_s  (in_s[3]),
      .mode    (mode)
   );

   pwr_clk_en_gen #(.NUM_DOMAINS(NUM_DOMAINS), .SLEEP_KEEP_MASK(SLEEP_KEEP_MASK)) u_en (
      .mode     (mode),
      .mode_ind (mode_ind),
      .clk_en   (clk_en)
   );

   // R5: the indicator never claims operation without every clock running
   assert_ind_en_R5: assert property (@(posedge clk) disable iff (!srst_n)
      mode_ind |-> (&clk_en));

   // R1: a held reset keeps every enable off
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!mode_ind && clk_en == '0));

endmodule

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;

   localparam int              ND   = 4;
   localparam int              SC   = 16;
   localparam logic [ND-1:0]   KEEP = 4'b0001;
   localparam int M_BOOT = 0, M_RUN = 1, M_SLEEP = 2, M_HOST = 3, M_OFF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic wake = 1'b0, pdn_n = 1'b1, spi_cs_n = 1'b1, spi_busy = 1'b0;
   logic mode_ind;
   logic [ND-1:0] clk_en;

   int total = 0, bad = 0;
   int em = M_BOOT;
   bit done = 0;

   pwr_seq_ctrl #(.NUM_DOMAINS(ND), .STARTUP_CYCLES(SC), .SYNC_STAGES(2),
                  .SLEEP_KEEP_MASK(KEEP)) uut (
      .clk(clk), .rst_n(rst_n), .wake(wake), .pdn_n(pdn_n),
      .spi_cs_n(spi_cs_n), .spi_busy(spi_busy),
      .mode_ind(mode_ind), .clk_en(clk_en)
   );

   always #5 clk = ~clk;

   function automatic logic exp_ind(input int m);
      return (m == M_RUN) || (m == M_HOST);
   endfunction

   function automatic logic [ND-1:0] exp_en(input int m);
      if (m == M_RUN || m == M_HOST) return '1;
      if (m == M_SLEEP) return KEEP;
      return '0;
   endfunction

   function automatic int next_mode(input int m, input logic w, input logic p,
                                    input logic cs, input logic bz, input logic pcs);
      if (m == M_OFF) return M_OFF;
      if (!p) return M_OFF;
      case (m)
         M_RUN:   return w ? M_RUN : M_SLEEP;
         M_SLEEP: return w ? M_RUN : ((pcs && !cs) ? M_HOST : M_SLEEP);
         M_HOST:  return (cs && !bz) ? (w ? M_RUN : M_SLEEP) : M_HOST;
         default: return m;
      endcase
   endfunction

   function automatic string tag_for(input int o, input int n, input logic pcs, input logic cs);
      if (n == M_OFF) return (o == M_OFF) ? "R10" : "R9";
      if (o == M_RUN && n == M_SLEEP) return "R4";
      if (o == M_SLEEP && n == M_RUN) return "R5";
      if (o == M_SLEEP && n == M_HOST) return "R6";
      if (o == M_HOST && n == M_HOST) return "R7";
      if (o == M_HOST) return "R8";
      if (o == M_RUN && pcs && !cs) return "R11";
      return "R3";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_out(input string tag);
      chk(tag, 32'(mode_ind), 32'(exp_ind(em)));
      chk(tag, 32'(clk_en), 32'(exp_en(em)));
   endtask

   task automatic step(input logic w, input logic p, input logic cs, input logic bz,
                       input string tag);
      logic pcs;
      int   om;
      @(negedge clk);
      pcs = spi_cs_n;
      wake = w; pdn_n = p; spi_cs_n = cs; spi_busy = bz;
      om = em;
      em = next_mode(em, w, p, cs, bz, pcs);
      repeat (5) @(negedge clk);
      if (tag == "") chk_out(tag_for(om, em, pcs, cs));
      else           chk_out(tag);
   endtask

   task automatic do_reset(input logic w, input logic p);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", 32'(mode_ind), 32'd0);
      chk("R1", 32'(clk_en), 32'd0);
      repeat (3) @(negedge clk);
      wake = w; pdn_n = p; spi_cs_n = 1'b1; spi_busy = 1'b0;
      rst_n = 1'b1;
      repeat (SC + 10) @(negedge clk);
      em = !p ? M_OFF : (w ? M_RUN : M_SLEEP);
      chk_out("R2");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int cyc;
      int r;
      logic nw, ncs, nbz, np;
      void'($urandom(32'd7321));
      #1 rst_n = 1'b0;
      #2;
      // R1: asynchronous reset before any clock edge
      chk("R1", 32'(mode_ind), 32'd0);
      chk("R1", 32'(clk_en), 32'd0);
      repeat (3) @(negedge clk);
      chk("R1", 32'(clk_en), 32'd0);

      // R2: start-up wait with wake high
      wake = 1'b1;
      rst_n = 1'b1;
      cyc = 0;
      for (int i = 1; i <= SC + 10; i++) begin
         @(negedge clk);
         if (mode_ind) begin cyc = i; break; end
         if (clk_en != '0) chk("R2", 32'(clk_en), 32'd0);
      end
      chk("R2", 32'((cyc >= SC) && (cyc <= SC + 4)), 32'd1);
      em = M_RUN;
      chk_out("R2");

      // R3: two-stage synchroniser latency
      @(negedge clk);
      wake = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R3", 32'(mode_ind), 32'd1);
      @(negedge clk);
      chk("R3", 32'(mode_ind), 32'd0);
      em = M_SLEEP;
      chk_out("R4");

      step(1, 1, 1, 0, "R5");
      step(0, 1, 1, 0, "R4");
      // R6 / R8: chip-select wake and release to sleep
      step(0, 1, 0, 0, "R6");
      step(0, 1, 1, 0, "R8");
      // R11 then R6 corner: chip select already low when sleep begins
      step(1, 1, 1, 0, "R5");
      step(1, 1, 0, 0, "R11");
      step(0, 1, 0, 0, "R6");
      step(0, 1, 1, 0, "R6");
      // R7: busy outlasts chip select, wake toggling meanwhile
      step(0, 1, 0, 1, "R6");
      step(0, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      step(0, 1, 1, 1, "R7");
      step(0, 1, 1, 0, "R8");
      // R8: access ends with wake high
      step(0, 1, 0, 0, "R6");
      step(1, 1, 0, 0, "R7");
      step(1, 1, 1, 0, "R8");
      // R9 / R10: power-down from operating, then stickiness
      step(1, 0, 1, 0, "R9");
      step(1, 1, 1, 0, "R10");
      step(0, 1, 1, 0, "R10");
      step(0, 1, 0, 0, "R10");
      step(1, 1, 1, 0, "R10");
      do_reset(0, 1);
      chk("R10", 32'(em), 32'(M_SLEEP));
      // R9: power-down beats simultaneous wake and chip select
      step(1, 0, 0, 0, "R9");
      do_reset(0, 1);
      // R9: power-down during host wake
      step(0, 1, 0, 1, "R6");
      step(0, 0, 0, 1, "R9");
      do_reset(1, 1);

      // random walk
      for (int it = 0; it < 300; it++) begin
         nw = wake; ncs = spi_cs_n; nbz = spi_busy; np = 1'b1;
         r = int'($urandom % 16);
         if (r < 5)       nw  = 1'($urandom);
         else if (r < 10) ncs = ~spi_cs_n;
         else if (r < 14) nbz = 1'($urandom);
         else if (r == 14) begin nw = 1'($urandom); ncs = 1'($urandom); end
         else if (($urandom % 3) == 0) np = 1'b0;
         step(nw, np, ncs, nbz, "");
         if (em == M_OFF) begin
            step(1'($urandom), 1'b1, 1'($urandom), 1'($urandom), "R10");
            do_reset(1'($urandom), 1'b1);
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule